// File: doc/BRIEF.md
# Paged Address Generator

This block builds the 20-bit memory address of a small 16-bit processor. It holds four address registers. Each one pairs a 16-bit offset with a 4-bit page value. Register 0 acts as the program counter, and a second register (by default register 3) acts as the workspace pointer. For a register-relative access, the low 16 address bits are the offset of the chosen register. The upper nibble is the bitwise OR of that register's page value and a 4-bit displacement taken from the instruction. No mode bit exists. With a page of zero the displacement picks the 64K region, and with a displacement of zero the page does.

The block also forms direct addresses into two small word tables at the bottom of memory. The zero page holds 64 words at word addresses 0 to 63. The vector page holds 64 words at word addresses 64 to 127. The vector page is used instead of the zero page when the word being read is headed for the program counter or the workspace pointer. Addresses are byte addresses, so bit 0 picks the byte within a word. The block drives two byte-lane enables from that bit and from the access width. Register offsets are loaded from the data path, and page values are loaded by a separate move-to-page write.

Top module: `agen_top`

## Requirements
- R1: While reset is asserted and after it is released, all four offsets and all four page values read as zero. A register-relative access then yields address = {displacement, 16'h0000}.
- R2: An offset write (ofs_we=1) loads ofs_wdata into the register selected by ofs_wsel at the clock edge. The new value appears on mem_addr[15:0] for later register-relative accesses to that register.
- R3: A page write (pg_we=1) loads pg_wdata into the page value of the register selected by pg_wsel. It leaves every offset unchanged.
- R4: In a register-relative access (acc_zp=0), mem_addr[19:16] equals page[acc_reg] OR acc_disp, bit by bit.
- R5: In a register-relative access, mem_addr[15:0] equals the offset of register acc_reg.
- R6: In a direct access (acc_zp=1) with no vector redirect, mem_addr = {12'h000, 1'b0, zp_idx, 1'b0}. The register offsets, page values and acc_disp have no effect on it.
- R7: In a direct access, the vector redirect applies when zp_dst_areg=1 and zp_dst selects register 0 (program counter) or the workspace-pointer register (index 3). The redirect sets address bit 7, giving {12'h000, 1'b1, zp_idx, 1'b0}.
- R8: A direct access whose destination is a data register (zp_dst_areg=0), or address register 1 or 2, is not redirected.
- R9: With byte_acc=0, lane_en=2'b11. With byte_acc=1, lane_en=2'b01 when mem_addr[0]=0 and 2'b10 when mem_addr[0]=1.
- R10: An offset write and a page write to the same register in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ofs_we | input | 1 | Offset write enable |
| ofs_wsel | input | 2 | Register receiving the offset write |
| ofs_wdata | input | 16 | Offset write data |
| pg_we | input | 1 | Page write enable |
| pg_wsel | input | 2 | Register receiving the page write |
| pg_wdata | input | 4 | Page write data |
| acc_zp | input | 1 | 1 = direct table access, 0 = register-relative access |
| acc_reg | input | 2 | Address register used for a register-relative access |
| acc_disp | input | 4 | Instruction displacement |
| zp_idx | input | 6 | Word index within the zero or vector page |
| zp_dst_areg | input | 1 | Destination of the direct read is an address register |
| zp_dst | input | 2 | Destination address register index |
| byte_acc | input | 1 | 1 = byte access, 0 = word access |
| mem_addr | output | 20 | Byte address |
| lane_en | output | 2 | Byte-lane enables {high, low} |

## Verification
Several checks run on every cycle. They cover three things: the displacement bits always appear in the upper nibble of a register-relative address, direct accesses never leave the bottom 256 bytes and set bit 7 exactly when the destination is the program counter or workspace pointer, and the lane enables match the access width and address bit 0. The effects of offset and page writes are also checked each cycle, against the value written one cycle earlier. Other behaviour can only be shown by the bench's scenarios and its cycle-by-cycle reference model. That includes the OR merging of a non-zero page with a non-zero displacement, writes to one register leaving the other three untouched, simultaneous writes to the same register, and the reset state.

// File: rtl/agen_pkg.sv
package agen_pkg;
  localparam int unsigned AGEN_NREG  = 4;
  localparam int unsigned AGEN_OFS_W = 16;
  localparam int unsigned AGEN_PG_W  = 4;
  localparam int unsigned AGEN_ZP_W  = 6;

  typedef enum logic {
    ACC_REL = 1'b0,
    ACC_TBL = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/agen_rst_sync.sv
module agen_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/agen_regfile.sv
module agen_regfile #(
  parameter int unsigned NREG  = agen_pkg::AGEN_NREG,
  parameter int unsigned OFS_W = agen_pkg::AGEN_OFS_W,
  parameter int unsigned PG_W  = agen_pkg::AGEN_PG_W,
  localparam int unsigned SEL_W = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ofs_we,
  input  logic [SEL_W-1:0]          ofs_wsel,
  input  logic [OFS_W-1:0]          ofs_wdata,
  input  logic                      pg_we,
  input  logic [SEL_W-1:0]          pg_wsel,
  input  logic [PG_W-1:0]           pg_wdata,
  output logic [NREG-1:0][OFS_W-1:0] ofs_q,
  output logic [NREG-1:0][PG_W-1:0]  pg_q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic             ofs_en;
    logic             pg_en;
    logic [OFS_W-1:0] ofs_d;
    logic [PG_W-1:0]  pg_d;

    always_comb begin
      ofs_en = ofs_we && (ofs_wsel == SEL_W'(g));
      pg_en  = pg_we  && (pg_wsel  == SEL_W'(g));
      ofs_d  = ofs_en ? ofs_wdata : ofs_q[g];
      pg_d   = pg_en  ? pg_wdata  : pg_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ofs_q[g] <= '0;
        pg_q[g]  <= '0;
      end else begin
        ofs_q[g] <= ofs_d;
        pg_q[g]  <= pg_d;
      end
    end
  end
endmodule

// File: rtl/agen_former.sv
module agen_former #(
  parameter int unsigned NREG   = agen_pkg::AGEN_NREG,
  parameter int unsigned OFS_W  = agen_pkg::AGEN_OFS_W,
  parameter int unsigned PG_W   = agen_pkg::AGEN_PG_W,
  parameter int unsigned ZP_W   = agen_pkg::AGEN_ZP_W,
  parameter int unsigned WP_IDX = 3,
  localparam int unsigned SEL_W  = $clog2(NREG),
  localparam int unsigned ADDR_W = OFS_W + PG_W
) (
  input  agen_pkg::acc_kind_e        kind,
  input  logic [SEL_W-1:0]           acc_reg,
  input  logic [PG_W-1:0]            acc_disp,
  input  logic [ZP_W-1:0]            zp_idx,
  input  logic                       zp_dst_areg,
  input  logic [SEL_W-1:0]           zp_dst,
  input  logic [NREG-1:0][OFS_W-1:0] ofs_q,
  input  logic [NREG-1:0][PG_W-1:0]  pg_q,
  output logic [ADDR_W-1:0]          addr
);
  localparam int unsigned TBL_PAD = ADDR_W - ZP_W - 2;

  logic              vec_hit;
  logic [ADDR_W-1:0] rel_addr;
  logic [ADDR_W-1:0] tbl_addr;

  always_comb begin
    vec_hit  = zp_dst_areg &&
               ((zp_dst == SEL_W'(0)) || (zp_dst == SEL_W'(WP_IDX)));
    rel_addr = {pg_q[acc_reg] | acc_disp, ofs_q[acc_reg]};
    tbl_addr = {{TBL_PAD{1'b0}}, vec_hit, zp_idx, 1'b0};
    addr     = (kind == agen_pkg::ACC_TBL) ? tbl_addr : rel_addr;
  end
endmodule

// File: rtl/agen_lane.sv
module agen_lane (
  input  logic       byte_acc,
  input  logic       addr_lsb,
  output logic [1:0] lane_en
);
  always_comb begin
    if (!byte_acc)     lane_en = 2'b11;
    else if (addr_lsb) lane_en = 2'b10;
    else               lane_en = 2'b01;
  end
endmodule

// File: rtl/agen_top.sv
module agen_top #(
  parameter int unsigned NREG   = agen_pkg::AGEN_NREG,
  parameter int unsigned OFS_W  = agen_pkg::AGEN_OFS_W,
  parameter int unsigned PG_W   = agen_pkg::AGEN_PG_W,
  parameter int unsigned ZP_W   = agen_pkg::AGEN_ZP_W,
  parameter int unsigned WP_IDX = 3,
  localparam int unsigned SEL_W  = $clog2(NREG),
  localparam int unsigned ADDR_W = OFS_W + PG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ofs_we,
  input  logic [SEL_W-1:0]  ofs_wsel,
  input  logic [OFS_W-1:0]  ofs_wdata,
  input  logic              pg_we,
  input  logic [SEL_W-1:0]  pg_wsel,
  input  logic [PG_W-1:0]   pg_wdata,
  input  logic              acc_zp,
  input  logic [SEL_W-1:0]  acc_reg,
  input  logic [PG_W-1:0]   acc_disp,
  input  logic [ZP_W-1:0]   zp_idx,
  input  logic              zp_dst_areg,
  input  logic [SEL_W-1:0]  zp_dst,
  input  logic              byte_acc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        lane_en
);
  logic                       rst_n_int;
  logic [NREG-1:0][OFS_W-1:0] ofs_q;
  logic [NREG-1:0][PG_W-1:0]  pg_q;
  agen_pkg::acc_kind_e        kind;

  assign kind = acc_zp ? agen_pkg::ACC_TBL : agen_pkg::ACC_REL;

  agen_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  agen_regfile #(.NREG(NREG), .OFS_W(OFS_W), .PG_W(PG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .ofs_we    (ofs_we),
    .ofs_wsel  (ofs_wsel),
    .ofs_wdata (ofs_wdata),
    .pg_we     (pg_we),
    .pg_wsel   (pg_wsel),
    .pg_wdata  (pg_wdata),
    .ofs_q     (ofs_q),
    .pg_q      (pg_q)
  );

  agen_former #(.NREG(NREG), .OFS_W(OFS_W), .PG_W(PG_W), .ZP_W(ZP_W),
                .WP_IDX(WP_IDX)) u_form (
    .kind        (kind),
    .acc_reg     (acc_reg),
    .acc_disp    (acc_disp),
    .zp_idx      (zp_idx),
    .zp_dst_areg (zp_dst_areg),
    .zp_dst      (zp_dst),
    .ofs_q       (ofs_q),
    .pg_q        (pg_q),
    .addr        (mem_addr)
  );

  agen_lane u_lane (
    .byte_acc (byte_acc),
    .addr_lsb (mem_addr[0]),
    .lane_en  (lane_en)
  );
endmodule

// File: rtl/agen_chk.sv
module agen_chk #(
  parameter int unsigned NREG   = agen_pkg::AGEN_NREG,
  parameter int unsigned OFS_W  = agen_pkg::AGEN_OFS_W,
  parameter int unsigned PG_W   = agen_pkg::AGEN_PG_W,
  parameter int unsigned ZP_W   = agen_pkg::AGEN_ZP_W,
  parameter int unsigned WP_IDX = 3,
  localparam int unsigned SEL_W  = $clog2(NREG),
  localparam int unsigned ADDR_W = OFS_W + PG_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ofs_we,
  input logic [SEL_W-1:0]  ofs_wsel,
  input logic [OFS_W-1:0]  ofs_wdata,
  input logic              pg_we,
  input logic [SEL_W-1:0]  pg_wsel,
  input logic [PG_W-1:0]   pg_wdata,
  input logic              acc_zp,
  input logic [SEL_W-1:0]  acc_reg,
  input logic [PG_W-1:0]   acc_disp,
  input logic [ZP_W-1:0]   zp_idx,
  input logic              zp_dst_areg,
  input logic [SEL_W-1:0]  zp_dst,
  input logic              byte_acc,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        lane_en
);
  logic past_ok;
  logic [2:0] settle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) settle_q <= '0;
    else if (settle_q != 3'd7) settle_q <= settle_q + 3'd1;
  end
  assign past_ok = (settle_q == 3'd7);

  // R4
  disp_in_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_zp |-> ((mem_addr[ADDR_W-1:OFS_W] & acc_disp) == acc_disp));

  // R6
  tbl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_zp |-> (mem_addr[ADDR_W-1:ZP_W+2] == '0 && mem_addr[0] == 1'b0));

  // R7
  vec_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_zp && zp_dst_areg && (zp_dst == SEL_W'(0) || zp_dst == SEL_W'(WP_IDX)))
      |-> mem_addr[ZP_W+1]);

  // R8
  vec_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_zp && !(zp_dst_areg && (zp_dst == SEL_W'(0) || zp_dst == SEL_W'(WP_IDX))))
      |-> !mem_addr[ZP_W+1]);

  // R9
  lane_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_acc |-> (lane_en == 2'b11));

  // R9
  lane_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_acc |-> ($countones(lane_en) == 1 && lane_en[1] == mem_addr[0]));

  // R2
  ofs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(ofs_we) && !acc_zp && acc_reg == $past(ofs_wsel))
      |-> (mem_addr[OFS_W-1:0] == $past(ofs_wdata)));

  // R3
  pg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(pg_we) && !acc_zp && acc_reg == $past(pg_wsel) && acc_disp == '0)
      |-> (mem_addr[ADDR_W-1:OFS_W] == $past(pg_wdata)));
endmodule

bind agen_top agen_chk #(.NREG(NREG), .OFS_W(OFS_W), .PG_W(PG_W), .ZP_W(ZP_W),
                         .WP_IDX(WP_IDX)) u_chk (.*);

// File: tb/sim_agen_top.sv
module sim_agen_top;
  logic        clk;
  logic        rst_n;
  logic        ofs_we;
  logic [1:0]  ofs_wsel;
  logic [15:0] ofs_wdata;
  logic        pg_we;
  logic [1:0]  pg_wsel;
  logic [3:0]  pg_wdata;
  logic        acc_zp;
  logic [1:0]  acc_reg;
  logic [3:0]  acc_disp;
  logic [5:0]  zp_idx;
  logic        zp_dst_areg;
  logic [1:0]  zp_dst;
  logic        byte_acc;
  logic [19:0] mem_addr;
  logic [1:0]  lane_en;

  int n_chk;
  int n_fail;
  int cyc;
  logic [15:0] m_ofs [4];
  logic [3:0]  m_pg  [4];

  agen_top u0 (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic idle();
    ofs_we = 0; ofs_wsel = 0; ofs_wdata = 0;
    pg_we = 0; pg_wsel = 0; pg_wdata = 0;
    acc_zp = 0; acc_reg = 0; acc_disp = 0; zp_idx = 0;
    zp_dst_areg = 0; zp_dst = 0; byte_acc = 0;
  endtask

  function automatic logic [19:0] exp_addr();
    logic vec;
    if (acc_zp) begin
      vec = zp_dst_areg && (zp_dst == 2'd0 || zp_dst == 2'd3);
      return 20'(vec) * 20'd128 + 20'(zp_idx) * 20'd2;
    end
    return {m_pg[acc_reg] | acc_disp, m_ofs[acc_reg]};
  endfunction

  // Inputs already set after negedge; check 1 ns later, then commit model.
  task automatic step(input string tag);
    logic [19:0] ea;
    logic [1:0]  el;
    #1;
    ea = exp_addr();
    el = !byte_acc ? 2'b11 : (ea[0] ? 2'b10 : 2'b01);
    chk(tag, 32'(mem_addr), 32'(ea));
    chk("R9 lanes", 32'(lane_en), 32'(el));
    @(posedge clk);
    if (ofs_we) m_ofs[ofs_wsel] = ofs_wdata;
    if (pg_we)  m_pg[pg_wsel]   = pg_wdata;
    @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0;
    for (int i = 0; i < 4; i++) begin m_ofs[i] = 0; m_pg[i] = 0; end
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    acc_disp = 4'hA; acc_reg = 2;
    #1 chk("R1 reset addr", 32'(mem_addr), 32'h000A0000);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 after release
    step("R1 post-reset");

    // R2 offset write then read
    idle(); ofs_we = 1; ofs_wsel = 1; ofs_wdata = 16'h1235;
    step("R5 during write");
    idle(); acc_reg = 1;
    step("R2 offset visible");
    // R3 page write keeps offset
    idle(); pg_we = 1; pg_wsel = 1; pg_wdata = 4'h5;
    step("R3 page write");
    idle(); acc_reg = 1; acc_disp = 4'hA;
    step("R4 page|disp");
    idle(); acc_reg = 1; acc_disp = 4'h4; byte_acc = 1;
    step("R4 overlap R9 byte hi");
    // R10 simultaneous
    idle(); ofs_we = 1; pg_we = 1; ofs_wsel = 3; pg_wsel = 3;
    ofs_wdata = 16'hBEEF; pg_wdata = 4'h9;
    step("R10 write cycle");
    idle(); acc_reg = 3;
    step("R10 both taken");
    // R6/R7/R8 direct accesses, registers loaded to show no effect
    idle(); acc_zp = 1; zp_idx = 6'h3F; acc_reg = 3; acc_disp = 4'hF;
    step("R6 zero page ignores regs");
    idle(); acc_zp = 1; zp_idx = 6'h15; zp_dst_areg = 1; zp_dst = 0;
    step("R7 vector for PC");
    idle(); acc_zp = 1; zp_idx = 6'h01; zp_dst_areg = 1; zp_dst = 3;
    step("R7 vector for WP");
    idle(); acc_zp = 1; zp_idx = 6'h2A; zp_dst_areg = 1; zp_dst = 2;
    step("R8 areg2 no vector");
    idle(); acc_zp = 1; zp_idx = 6'h2A; zp_dst_areg = 0; zp_dst = 0; byte_acc = 1;
    step("R8 data dest no vector");

    // mixed traffic against model
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      ofs_we = r[0]; ofs_wsel = r[2:1]; ofs_wdata = $urandom;
      pg_we = r[3]; pg_wsel = r[5:4]; pg_wdata = r[9:6];
      acc_zp = (r[12:10] == 3'd0); acc_reg = r[14:13]; acc_disp = r[18:15];
      zp_idx = r[24:19]; zp_dst_areg = r[25]; zp_dst = r[27:26]; byte_acc = r[28];
      step(acc_zp ? "R6 R7 R8 mixed direct" : "R4 R5 mixed relative");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule